// File: doc/BRIEF.md
# Program Counter Sequencer with Hardware Return Stack

This block produces the instruction fetch address of a small 8-bit processor core. A 12-bit program counter steps through a 4K-word program space. On each cycle the block picks the next address from one of several sources: the incremented counter, a branch target supplied by decode, a new low byte written by software that stays within the current 256-word page, the top of an 8-entry return stack, or a fixed interrupt vector. Any change of flow discards the instruction that has already been fetched. The block marks the following cycle as a bubble, and no instruction executes in that cycle.

The sequencer is a two-state machine. State `ST_EXEC` is a normal execute cycle: decode strobes are acted on, and a pending interrupt may be taken. State `ST_BUBBLE` is the dummy cycle that follows every change of flow: strobes are ignored and the counter only increments. Reset enters `ST_BUBBLE`. The transition `ST_EXEC -> ST_BUBBLE` fires on return, call, jump, page write, taken skip or interrupt entry. The transitions `ST_EXEC -> ST_EXEC` (plain step) and `ST_BUBBLE -> ST_EXEC` (always) complete the graph.

Interrupt requests are latched as pending bits. An interrupt is taken only under four conditions: the global enable is set, the machine is in `ST_EXEC`, no decode strobe is active, and the return stack has a free level. While the stack is full, a request waits until a return frees a level. A call is never blocked: it pushes anyway, wraps the stack pointer and overwrites the oldest entry.

Top module: `pc_sequencer`

## Requirements
- R1: While reset is asserted, `fetch_pc` is 000h, `bubble` is 1, `stk_level` is 0 and `irq_ack` is 0. One clock edge after reset is released, `fetch_pc` is 001h and `bubble` is 0.
- R2: In an execute cycle with no strobe and no interrupt entry, the next `fetch_pc` is the current value plus one (mod 4096) and `bubble` stays 0.
- R3: An accepted jump or call loads `tgt_addr` into `fetch_pc` at the next edge, with `bubble` high for that one cycle. A call also pushes the current `fetch_pc` and raises `stk_level` by one, up to a maximum of 8.
- R4: An accepted return (`ex_ret` or `ex_reti`) loads the most recently pushed address, lowers `stk_level` by one (never below 0) and causes one bubble. `ex_reti` also sets the interrupt enable again.
- R5: An accepted page write sets `fetch_pc` to {current `fetch_pc`[11:8], `pcl_data`} and causes one bubble.
- R6: An accepted skip advances `fetch_pc` by one and causes one bubble.
- R7: In a bubble cycle every strobe is ignored, `fetch_pc` increments by one, and `bubble` is never high for two cycles in a row.
- R8: When several strobes are active in one execute cycle, exactly one is accepted, in this order of precedence: return, call, jump, page write, skip. Interrupt entry ranks below all of them.
- R9: An interrupt is taken (`irq_ack`=1 in that cycle) only under four conditions: the enable is set, the cycle is an execute cycle, no strobe is active, and `stk_level` < 8. Source i (bit i of `irq_req`) vectors to 4*(i+1), so bit 0 goes to 004h, bit 1 to 008h and bit 2 to 00Ch. The lowest pending index wins. Entry pushes the current `fetch_pc`, clears the enable and clears that source's pending bit.
- R10: While `stk_level` is 8, a pending enabled request is not acknowledged. It is taken in the first execute cycle after a return has freed a level.
- R11: A call made while `stk_level` is 8 still pushes, overwriting the oldest entry, and `stk_level` stays 8. A return from an empty stack yields the entry at the wrapped pointer, and `stk_level` stays 0.
- R12: A one-cycle pulse on `irq_req` is held pending while the enable is clear. It is taken once `ex_int_en` sets the enable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ex_jump | input | 1 | Decoded jump strobe |
| ex_call | input | 1 | Decoded call strobe |
| ex_ret | input | 1 | Decoded return strobe |
| ex_reti | input | 1 | Decoded return-from-interrupt strobe |
| ex_pcl_wr | input | 1 | Write of the counter low byte |
| ex_skip | input | 1 | Skip condition met |
| ex_int_en | input | 1 | Set the global interrupt enable |
| tgt_addr | input | 12 | Jump or call target |
| pcl_data | input | 8 | New low byte for a page write |
| irq_req | input | 3 | Interrupt request pulses, bit 0 has the highest priority |
| fetch_pc | output | 12 | Current fetch address |
| bubble | output | 1 | Current cycle is a dummy cycle |
| irq_ack | output | 1 | Interrupt entry in this cycle |
| stk_level | output | 4 | Number of valid return stack entries, 0 to 8 |

## Verification
The sharpest collision is a pending interrupt meeting a return while the stack is full. The bench fills all eight levels with interrupts enabled, posts a request, and confirms that no acknowledge appears over several plain cycles. It then issues a return: the pop must win that cycle, the bubble must pass with no acknowledge, and the vector entry must appear in the following execute cycle with the level back at eight. A second collision stacks every strobe into one cycle and into bubble cycles. Precedence and the ignore rule are judged from the resulting `fetch_pc` and `stk_level`.

// File: rtl/pcseq_pkg.sv
package pcseq_pkg;

    typedef enum logic {
        ST_EXEC   = 1'b0,
        ST_BUBBLE = 1'b1
    } seq_state_e;

    typedef enum logic [2:0] {
        SRC_SEQ    = 3'd0,
        SRC_RET    = 3'd1,
        SRC_CALL   = 3'd2,
        SRC_JUMP   = 3'd3,
        SRC_PAGE   = 3'd4,
        SRC_SKIP   = 3'd5,
        SRC_VECTOR = 3'd6
    } next_src_e;

endpackage

// File: rtl/pcseq_rstack.sv
module pcseq_rstack #(
    parameter int W     = 12,
    parameter int DEPTH = 8
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         push,
    input  logic                         pop,
    input  logic [W-1:0]                 wdata,
    output logic [W-1:0]                 top,
    output logic [$clog2(DEPTH+1)-1:0]   level
);
    // DEPTH is a power of two so the pointer wraps naturally.
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int LVL_W = $clog2(DEPTH + 1);

    logic [W-1:0]     ent [DEPTH];
    logic [PTR_W-1:0] wptr;
    logic [PTR_W-1:0] rd_idx;

    assign rd_idx = wptr - PTR_W'(1);
    assign top    = ent[rd_idx];

    for (genvar i = 0; i < DEPTH; i++) begin : g_ent
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
                ent[i] <= '0;
            else if (push && (wptr == PTR_W'(i)))
                ent[i] <= wdata;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wptr  <= '0;
            level <= '0;
        end else if (push) begin
            wptr <= wptr + PTR_W'(1);
            if (level != LVL_W'(DEPTH))
                level <= level + LVL_W'(1);
        end else if (pop) begin
            wptr <= rd_idx;
            if (level != '0)
                level <= level - LVL_W'(1);
        end
    end

endmodule

// File: rtl/pcseq_irq_arb.sv
module pcseq_irq_arb #(
    parameter int NIRQ = 3
) (
    input  logic                                   clk,
    input  logic                                   rst_n,
    input  logic [NIRQ-1:0]                        req,
    input  logic                                   en_set,
    input  logic                                   en_restore,
    input  logic                                   take,
    output logic                                   ready,
    output logic [((NIRQ > 1) ? $clog2(NIRQ) : 1)-1:0] win
);
    localparam int IDX_W = (NIRQ > 1) ? $clog2(NIRQ) : 1;

    logic [NIRQ-1:0] pend;
    logic [NIRQ-1:0] clr;
    logic            gie;

    // Lowest index has the highest priority: scan downward, last hit wins.
    always_comb begin
        win = '0;
        for (int i = NIRQ - 1; i >= 0; i--) begin
            if (pend[i])
                win = IDX_W'(i);
        end
    end

    always_comb begin
        for (int i = 0; i < NIRQ; i++)
            clr[i] = take && (win == IDX_W'(i));
    end

    assign ready = gie && (|pend);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pend <= '0;
            gie  <= 1'b0;
        end else begin
            pend <= (pend & ~clr) | req;
            if (take)
                gie <= 1'b0;
            else if (en_set || en_restore)
                gie <= 1'b1;
        end
    end

endmodule

// File: rtl/pc_sequencer.sv
module pc_sequencer
    import pcseq_pkg::*;
#(
    parameter int PC_W       = 12,
    parameter int STK_DEPTH  = 8,
    parameter int NIRQ       = 3,
    parameter int VEC_STRIDE = 4
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic                           ex_jump,
    input  logic                           ex_call,
    input  logic                           ex_ret,
    input  logic                           ex_reti,
    input  logic                           ex_pcl_wr,
    input  logic                           ex_skip,
    input  logic                           ex_int_en,
    input  logic [PC_W-1:0]                tgt_addr,
    input  logic [7:0]                     pcl_data,
    input  logic [NIRQ-1:0]                irq_req,
    output logic [PC_W-1:0]                fetch_pc,
    output logic                           bubble,
    output logic                           irq_ack,
    output logic [$clog2(STK_DEPTH+1)-1:0] stk_level
);
    localparam int LVL_W = $clog2(STK_DEPTH + 1);
    localparam int IDX_W = (NIRQ > 1) ? $clog2(NIRQ) : 1;

    seq_state_e       state, state_nxt;
    next_src_e        src;
    logic [PC_W-1:0]  pc_q, pc_nxt, stk_top, vec_addr;
    logic             push, pop, take, exec, stk_full, irq_ready;
    logic [IDX_W-1:0] irq_win;

    assign exec     = (state == ST_EXEC);
    assign stk_full = (stk_level == LVL_W'(STK_DEPTH));
    assign vec_addr = PC_W'((int'(irq_win) + 1) * VEC_STRIDE);

    pcseq_rstack #(.W(PC_W), .DEPTH(STK_DEPTH)) u_stack (
        .clk   (clk),
        .rst_n (rst_n),
        .push  (push),
        .pop   (pop),
        .wdata (pc_q),
        .top   (stk_top),
        .level (stk_level)
    );

    pcseq_irq_arb #(.NIRQ(NIRQ)) u_irq (
        .clk        (clk),
        .rst_n      (rst_n),
        .req        (irq_req),
        .en_set     (exec && ex_int_en),
        .en_restore (exec && ex_reti),
        .take       (take),
        .ready      (irq_ready),
        .win        (irq_win)
    );

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ST_BUBBLE;
            pc_q  <= '0;
        end else begin
            state <= state_nxt;
            pc_q  <= pc_nxt;
        end
    end

    // Transition: pick the address source and the next state
    always_comb begin
        src       = SRC_SEQ;
        state_nxt = ST_EXEC;
        unique case (state)
            ST_EXEC: begin
                if (ex_ret || ex_reti)            src = SRC_RET;
                else if (ex_call)                 src = SRC_CALL;
                else if (ex_jump)                 src = SRC_JUMP;
                else if (ex_pcl_wr)               src = SRC_PAGE;
                else if (ex_skip)                 src = SRC_SKIP;
                else if (irq_ready && !stk_full)  src = SRC_VECTOR;
                else                              src = SRC_SEQ;
                state_nxt = (src == SRC_SEQ) ? ST_EXEC : ST_BUBBLE;
            end
            ST_BUBBLE: begin
                src       = SRC_SEQ;
                state_nxt = ST_EXEC;
            end
        endcase
    end

    // Outputs of the chosen source
    always_comb begin
        pc_nxt = pc_q + PC_W'(1);
        push   = 1'b0;
        pop    = 1'b0;
        take   = 1'b0;
        unique case (src)
            SRC_SEQ:    pc_nxt = pc_q + PC_W'(1);
            SRC_RET:    begin pc_nxt = stk_top;  pop  = 1'b1; end
            SRC_CALL:   begin pc_nxt = tgt_addr; push = 1'b1; end
            SRC_JUMP:   pc_nxt = tgt_addr;
            SRC_PAGE:   pc_nxt = {pc_q[PC_W-1:8], pcl_data};
            SRC_SKIP:   pc_nxt = pc_q + PC_W'(1);
            SRC_VECTOR: begin pc_nxt = vec_addr; push = 1'b1; take = 1'b1; end
            default:    pc_nxt = pc_q + PC_W'(1);
        endcase
    end

    assign fetch_pc = pc_q;
    assign bubble   = (state == ST_BUBBLE);
    assign irq_ack  = take;

endmodule

// File: rtl/pc_sequencer_chk.sv
module pc_sequencer_chk #(
    parameter int PC_W      = 12,
    parameter int STK_DEPTH = 8,
    parameter int NIRQ      = 3,
    parameter int VEC_STRIDE = 4
) (
    input logic                           clk,
    input logic                           rst_n,
    input logic                           ex_jump,
    input logic                           ex_call,
    input logic                           ex_ret,
    input logic                           ex_reti,
    input logic                           ex_pcl_wr,
    input logic                           ex_skip,
    input logic [7:0]                     pcl_data,
    input logic [PC_W-1:0]                fetch_pc,
    input logic                           bubble,
    input logic                           irq_ack,
    input logic [$clog2(STK_DEPTH+1)-1:0] stk_level
);
    localparam int LVL_W = $clog2(STK_DEPTH + 1);

    logic any_strobe;
    assign any_strobe = ex_jump || ex_call || ex_ret || ex_reti || ex_pcl_wr || ex_skip;

    assert_single_bubble_R7: assert property (@(posedge clk) disable iff (!rst_n)
        bubble |=> !bubble);

    assert_bubble_step_R7: assert property (@(posedge clk) disable iff (!rst_n)
        bubble |=> (fetch_pc == PC_W'($past(fetch_pc) + 1)));

    assert_plain_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (!bubble && !any_strobe && !irq_ack) |=>
            ((fetch_pc == PC_W'($past(fetch_pc) + 1)) && !bubble));

    assert_page_keep_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (!bubble && ex_pcl_wr && !ex_ret && !ex_reti && !ex_call && !ex_jump) |=>
            (fetch_pc == {$past(fetch_pc[PC_W-1:8]), $past(pcl_data)}));

    assert_call_level_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (!bubble && ex_call && !ex_ret && !ex_reti && (stk_level != LVL_W'(STK_DEPTH))) |=>
            (stk_level == LVL_W'($past(stk_level) + 1)));

    assert_ack_room_R10: assert property (@(posedge clk) disable iff (!rst_n)
        irq_ack |-> ((stk_level != LVL_W'(STK_DEPTH)) && !bubble && !any_strobe));

    assert_ack_vector_R9: assert property (@(posedge clk) disable iff (!rst_n)
        irq_ack |=> (bubble && (fetch_pc % VEC_STRIDE == 0) && (fetch_pc != '0)
                     && (int'(fetch_pc) <= NIRQ * VEC_STRIDE)));

endmodule

bind pc_sequencer pc_sequencer_chk #(
    .PC_W(PC_W), .STK_DEPTH(STK_DEPTH), .NIRQ(NIRQ), .VEC_STRIDE(VEC_STRIDE)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .ex_jump   (ex_jump),
    .ex_call   (ex_call),
    .ex_ret    (ex_ret),
    .ex_reti   (ex_reti),
    .ex_pcl_wr (ex_pcl_wr),
    .ex_skip   (ex_skip),
    .pcl_data  (pcl_data),
    .fetch_pc  (fetch_pc),
    .bubble    (bubble),
    .irq_ack   (irq_ack),
    .stk_level (stk_level)
);

// File: tb/tb_pc_sequencer.sv
module tb_pc_sequencer;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        ex_jump, ex_call, ex_ret, ex_reti, ex_pcl_wr, ex_skip, ex_int_en;
    logic [11:0] tgt_addr;
    logic [7:0]  pcl_data;
    logic [2:0]  irq_req;
    logic [11:0] fetch_pc;
    logic        bubble, irq_ack;
    logic [3:0]  stk_level;

    int n_chk  = 0;
    int n_fail = 0;

    always #2 clk = ~clk;

    pc_sequencer dut (
        .clk(clk), .rst_n(rst_n),
        .ex_jump(ex_jump), .ex_call(ex_call), .ex_ret(ex_ret), .ex_reti(ex_reti),
        .ex_pcl_wr(ex_pcl_wr), .ex_skip(ex_skip), .ex_int_en(ex_int_en),
        .tgt_addr(tgt_addr), .pcl_data(pcl_data), .irq_req(irq_req),
        .fetch_pc(fetch_pc), .bubble(bubble), .irq_ack(irq_ack), .stk_level(stk_level)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic clear_in();
        ex_jump = 0; ex_call = 0; ex_ret = 0; ex_reti = 0;
        ex_pcl_wr = 0; ex_skip = 0; ex_int_en = 0; irq_req = '0;
    endtask

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic reset_dut();
        rst_n = 0;
        clear_in();
        tgt_addr = '0; pcl_data = '0;
        @(posedge clk); #1;
        check("R1 reset pc", 32'(fetch_pc), 0);
        check("R1 reset bubble", 32'(bubble), 1);
        check("R1 reset level", 32'(stk_level), 0);
        check("R1 reset ack", 32'(irq_ack), 0);
        rst_n = 1;
        tick();
        check("R1 first pc", 32'(fetch_pc), 1);
        check("R1 first bubble", 32'(bubble), 0);
    endtask

    task automatic do_call(input logic [11:0] t, output logic [11:0] pushed);
        pushed = fetch_pc;
        ex_call = 1; tgt_addr = t;
        tick();
        ex_call = 0;
        check("R3 call target", 32'(fetch_pc), 32'(t));
        tick();
    endtask

    task automatic do_ret(input logic [11:0] exp_pc, input logic [3:0] exp_lvl, input bit use_reti);
        if (use_reti) ex_reti = 1; else ex_ret = 1;
        tick();
        ex_ret = 0; ex_reti = 0;
        check("R4 return pc", 32'(fetch_pc), 32'(exp_pc));
        check("R4 return level", 32'(stk_level), 32'(exp_lvl));
        check("R4 return bubble", 32'(bubble), 1);
        tick();
    endtask

    initial begin : main
        logic [11:0] rec [9];
        logic [11:0] exp_pc;
        logic [11:0] ra;

        reset_dut();

        // R2: plain stepping
        for (int i = 0; i < 10; i++) begin
            exp_pc = fetch_pc + 12'd1;
            tick();
            check("R2 step pc", 32'(fetch_pc), 32'(exp_pc));
            check("R2 step bubble", 32'(bubble), 0);
        end

        // R3 / R7: jump to every address; strobes during some bubbles
        for (int t = 0; t < 4096; t++) begin
            ex_jump = 1; tgt_addr = 12'(t);
            tick();
            ex_jump = 0;
            check("R3 jump pc", 32'(fetch_pc), 32'(t));
            check("R3 jump bubble", 32'(bubble), 1);
            if (t % 64 == 0) begin
                ex_jump = 1; ex_call = 1; ex_ret = 1; ex_pcl_wr = 1; ex_skip = 1;
                tgt_addr = 12'h5A5; pcl_data = 8'h3C;
            end
            tick();
            clear_in();
            check("R7 bubble step pc", 32'(fetch_pc), 32'((t + 1) & 12'hFFF));
            check("R7 bubble once", 32'(bubble), 0);
            if (t % 64 == 0)
                check("R7 bubble ignores call", 32'(stk_level), 0);
        end

        // R5: page writes keep the upper bits
        foreach (rec[k]) rec[k] = '0;
        for (int pi = 0; pi < 4; pi++) begin
            logic [3:0] pg;
            pg = (pi == 0) ? 4'h0 : (pi == 1) ? 4'h3 : (pi == 2) ? 4'h9 : 4'hF;
            ex_jump = 1; tgt_addr = {pg, 8'h80};
            tick(); ex_jump = 0; tick();
            for (int v = 0; v < 256; v++) begin
                ex_pcl_wr = 1; pcl_data = 8'(v);
                tick();
                ex_pcl_wr = 0;
                check("R5 page pc", 32'(fetch_pc), 32'({pg, 8'(v)}));
                check("R5 page bubble", 32'(bubble), 1);
                tick();
            end
        end

        // R6: taken skips
        for (int i = 0; i < 5; i++) begin
            exp_pc = fetch_pc + 12'd1;
            ex_skip = 1;
            tick();
            ex_skip = 0;
            check("R6 skip pc", 32'(fetch_pc), 32'(exp_pc));
            check("R6 skip bubble", 32'(bubble), 1);
            tick();
            check("R6 after skip pc", 32'(fetch_pc), 32'(exp_pc + 12'd1));
        end

        // R3 / R4: nesting depths 1..8
        for (int k = 1; k <= 8; k++) begin
            reset_dut();
            for (int j = 0; j < k; j++) begin
                do_call(12'(12'h100 + 16 * j + k), rec[j]);
                check("R3 call level", 32'(stk_level), 32'(j + 1));
            end
            for (int j = k - 1; j >= 0; j--)
                do_ret(rec[j], 4'(j), (j % 2) == 1);
        end

        // R11: overflow wraps, empty pop reads the wrapped slot
        reset_dut();
        for (int j = 0; j < 9; j++)
            do_call(12'(12'h200 + 8 * j), rec[j]);
        check("R11 level saturates", 32'(stk_level), 8);
        for (int j = 8; j >= 1; j--)
            do_ret(rec[j], 4'(j - 1), 1'b0);
        do_ret(rec[8], 4'd0, 1'b0);
        check("R11 empty pop level", 32'(stk_level), 0);

        // R8: strobe precedence
        reset_dut();
        do_call(12'h321, rec[0]);
        ex_ret = 1; ex_call = 1; ex_jump = 1; ex_pcl_wr = 1; ex_skip = 1;
        tgt_addr = 12'h444; pcl_data = 8'h55;
        tick(); clear_in();
        check("R8 return wins pc", 32'(fetch_pc), 32'(rec[0]));
        check("R8 return wins level", 32'(stk_level), 0);
        tick();
        ex_call = 1; ex_jump = 1; ex_pcl_wr = 1; ex_skip = 1; tgt_addr = 12'h6A0;
        tick(); clear_in();
        check("R8 call wins pc", 32'(fetch_pc), 32'h6A0);
        check("R8 call wins level", 32'(stk_level), 1);
        tick();
        ex_jump = 1; ex_pcl_wr = 1; ex_skip = 1; tgt_addr = 12'h7F3; pcl_data = 8'h11;
        tick(); clear_in();
        check("R8 jump wins pc", 32'(fetch_pc), 32'h7F3);
        tick();
        ex_pcl_wr = 1; ex_skip = 1; pcl_data = 8'h22;
        tick(); clear_in();
        check("R8 page beats skip", 32'(fetch_pc), 32'h722);
        tick();

        // R9 / R12: every combination of pending sources
        for (int m = 1; m < 8; m++) begin
            reset_dut();
            irq_req = 3'(m);
            tick();
            irq_req = '0;
            for (int i = 0; i < 3; i++) begin
                check("R12 held while disabled", 32'(irq_ack), 0);
                tick();
            end
            ex_int_en = 1;
            check("R12 no ack before enable", 32'(irq_ack), 0);
            tick();
            ex_int_en = 0;
            for (int s = 0; s < 3; s++) begin
                if (m[s]) begin
                    check("R9 ack priority", 32'(irq_ack), 1);
                    ra = fetch_pc;
                    tick();
                    check("R9 vector", 32'(fetch_pc), 32'(4 * (s + 1)));
                    check("R9 push level", 32'(stk_level), 1);
                    check("R9 vector bubble", 32'(bubble), 1);
                    tick();
                    check("R9 enable cleared", 32'(irq_ack), 0);
                    do_ret(ra, 4'd0, 1'b1);
                end
            end
            check("R9 drained", 32'(irq_ack), 0);
        end

        // R10: full stack holds off the interrupt until a return
        reset_dut();
        ex_int_en = 1;
        tick();
        ex_int_en = 0;
        for (int j = 0; j < 8; j++)
            do_call(12'(12'h800 + 4 * j), rec[j]);
        check("R10 full level", 32'(stk_level), 8);
        irq_req = 3'b001;
        tick();
        irq_req = '0;
        for (int i = 0; i < 4; i++) begin
            check("R10 held while full", 32'(irq_ack), 0);
            tick();
        end
        ex_ret = 1;
        check("R10 return beats irq", 32'(irq_ack), 0);
        tick();
        ex_ret = 0;
        check("R10 return level", 32'(stk_level), 7);
        check("R10 return pc", 32'(fetch_pc), 32'(rec[7]));
        check("R10 no ack in bubble", 32'(irq_ack), 0);
        tick();
        check("R10 taken after return", 32'(irq_ack), 1);
        tick();
        check("R10 vector pc", 32'(fetch_pc), 32'h004);
        check("R10 vector level", 32'(stk_level), 8);

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog (all requirements) actual=hung expected=done");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule